// File: doc/BRIEF.md
# Masked Frame-Field Filter Bank

This block watches bytes of received Ethernet frames as they stream past. It picks out one programmable window of up to six consecutive bytes from each frame. Eight filter slots compare that window against their own stored value. Each slot has a per-bit ignore mask and one of four compare kinds: off, equal, greater than or less than. The result is an 8-bit match vector, with one bit per slot, presented together with a one-cycle valid pulse as soon as the last window byte has been accepted. Typical uses are matching a destination address or an address range (window at byte 0, six bytes) or checking a source address (window at byte 6, six bytes).

The byte stream arrives on a valid/ready interface. The block never applies back-pressure: `in_ready` is held high, so every cycle with `in_valid` high is an accepted beat and the sender needs no flow control. Settings are loaded through a plain word-write port into staging registers. A snapshot of those registers is taken on each start-of-frame beat, so every frame is judged against one consistent set of settings.

Top module: `ffield_filter_bank`

## Requirements
- R1: After reset `match_vec` is 0, `match_valid` is 0 and `in_ready` is 1; every slot kind is off and the window length is 0.
- R2: Write map by word address: slot n uses 4n (value, window bytes 3..0 at bits 31:0, byte k at bits 8k+7:8k), 4n+1 (value, byte 4 at bits 7:0 and byte 5 at bits 15:8), 4n+2 and 4n+3 (mask, same layout). Address 32 holds the kinds, with slot n at bits 2n+1:2n. Address 33 holds the window, with the start byte offset at bits 14:0 and the length in bytes at bits 19:16.
- R3: Kind code 1 (equal) matches when every window bit whose mask bit is 0 equals the value bit; a mask bit of 1 ignores that bit.
- R4: Kind codes 2 (greater) and 3 (less) compare the masked window with the masked value as unsigned numbers whose most significant byte is the first received window byte; equality gives no match for either.
- R5: A slot with kind code 0 (off) never sets its match bit, whatever its value and mask hold.
- R6: `match_valid` pulses for one cycle in the cycle after the last window byte is accepted, and `match_vec` updates in that same cycle. `match_vec` then holds its value. It reads 0 from the cycle after the next start-of-frame beat, unless the window completes on that beat.
- R7: If a frame ends before its window is complete, no `match_valid` pulse occurs for it and `match_vec` stays 0.
- R8: A window length above 6 acts as 6. A length below 6 compares only the first bytes of value and mask. A length of 0 produces no result for the frame.
- R9: Register writes reach the compare logic only at the first start-of-frame beat after the write; a frame already in progress keeps its settings.
- R10: Cycles with `in_valid` low do not advance the frame, and beats after an end-of-frame beat that arrive without a new start-of-frame are ignored.
- R11: Bytes before the window start and after the window end have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| match_valid | output | 1 | One-cycle pulse: match vector is fresh |
| match_vec | output | 8 | One match bit per slot |

## Verification
The hardest situation to reach from the ports is a settings change landing in the middle of a frame. The frame in flight must keep its old settings, and the next frame must pick up the new ones. The bench reaches it by running a register write in parallel with a frame transfer, a few beats after its start, and then checking both that frame and the one after it. Window placement is also varied (source-address offset, a shortened window, an over-long and a zero length), and idle gaps and stray beats after end-of-frame are inserted, so that byte counting is checked separately from byte comparison.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
  localparam logic [1:0] KIND_OFF = 2'd0;
  localparam logic [1:0] KIND_EQ  = 2'd1;
  localparam logic [1:0] KIND_GT  = 2'd2;
  localparam logic [1:0] KIND_LT  = 2'd3;
  localparam int WORD_W  = 32;
  localparam int LEN_LSB = 16;
endpackage

// File: rtl/ffb_cfg_regs.sv
module ffb_cfg_regs
  import ffb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int FIELD_W   = 48,
  parameter int ADDR_W    = 6,
  parameter int START_W   = 15,
  parameter int LEN_W     = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [WORD_W-1:0]                  wr_data,
  input  logic                               load,
  output logic [NUM_SLOTS-1:0][FIELD_W-1:0]  cur_val,
  output logic [NUM_SLOTS-1:0][FIELD_W-1:0]  cur_mask,
  output logic [NUM_SLOTS-1:0][1:0]          cur_kind,
  output logic [START_W-1:0]                 cur_start,
  output logic [LEN_W-1:0]                   cur_len
);
  localparam int HI_W      = FIELD_W - WORD_W;
  localparam int KIND_ADDR = 4 * NUM_SLOTS;
  localparam int WIN_ADDR  = KIND_ADDR + 1;

  logic [NUM_SLOTS-1:0][FIELD_W-1:0] stg_val, stg_mask, act_val, act_mask;
  logic [NUM_SLOTS-1:0][1:0]         stg_kind, act_kind;
  logic [START_W-1:0]                stg_start, act_start;
  logic [LEN_W-1:0]                  stg_len, act_len;
  logic                              unused_wdata;

  assign unused_wdata = ^wr_data;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_val[s]  <= '0;
        stg_mask[s] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(4*s))
          stg_val[s][WORD_W-1:0] <= wr_data;
        if (wr_addr == ADDR_W'(4*s+1))
          stg_val[s][FIELD_W-1:WORD_W] <= wr_data[HI_W-1:0];
        if (wr_addr == ADDR_W'(4*s+2))
          stg_mask[s][WORD_W-1:0] <= wr_data;
        if (wr_addr == ADDR_W'(4*s+3))
          stg_mask[s][FIELD_W-1:WORD_W] <= wr_data[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_kind  <= '0;
      stg_start <= '0;
      stg_len   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(KIND_ADDR))
        stg_kind <= wr_data[2*NUM_SLOTS-1:0];
      if (wr_addr == ADDR_W'(WIN_ADDR)) begin
        stg_start <= wr_data[START_W-1:0];
        stg_len   <= wr_data[LEN_LSB +: LEN_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_val   <= '0;
      act_mask  <= '0;
      act_kind  <= '0;
      act_start <= '0;
      act_len   <= '0;
    end else if (load) begin
      act_val   <= stg_val;
      act_mask  <= stg_mask;
      act_kind  <= stg_kind;
      act_start <= stg_start;
      act_len   <= stg_len;
    end
  end

  assign cur_val   = load ? stg_val   : act_val;
  assign cur_mask  = load ? stg_mask  : act_mask;
  assign cur_kind  = load ? stg_kind  : act_kind;
  assign cur_start = load ? stg_start : act_start;
  assign cur_len   = load ? stg_len   : act_len;
endmodule

// File: rtl/ffb_window_capture.sv
module ffb_window_capture #(
  parameter int FIELD_BYTES = 6,
  parameter int START_W     = 15,
  parameter int LEN_W       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic [7:0]               in_data,
  input  logic [START_W-1:0]       win_start,
  input  logic [LEN_W-1:0]         win_len,
  output logic [8*FIELD_BYTES-1:0] win_bytes,
  output logic [LEN_W-1:0]         eff_len,
  output logic                     fire
);
  localparam int FIELD_W = 8 * FIELD_BYTES;
  localparam int POS_W   = START_W + 1;
  localparam int SUM_W   = POS_W + 1;
  localparam int IDX_W   = $clog2(FIELD_BYTES);

  logic [POS_W-1:0]   pos_q, pos_cur;
  logic [FIELD_W-1:0] win_q;
  logic               in_frame_q, done_q, done_cur;
  logic               beat, in_win, last;
  logic [SUM_W-1:0]   pos_ext, st_ext, end_ext, idx;
  logic [IDX_W-1:0]   idx_b;
  logic               unused_idx;

  assign beat     = in_valid && (in_sof || in_frame_q);
  assign pos_cur  = in_sof ? '0 : pos_q;
  assign done_cur = in_sof ? 1'b0 : done_q;
  assign eff_len  = (win_len > LEN_W'(FIELD_BYTES)) ? LEN_W'(FIELD_BYTES) : win_len;

  assign pos_ext = SUM_W'(pos_cur);
  assign st_ext  = SUM_W'(win_start);
  assign end_ext = st_ext + SUM_W'(eff_len);
  assign idx     = pos_ext - st_ext;
  assign idx_b   = idx[IDX_W-1:0];
  assign unused_idx = ^idx[SUM_W-1:IDX_W];

  assign in_win = beat && (pos_ext >= st_ext) && (pos_ext < end_ext);
  assign last   = (idx == SUM_W'(eff_len) - SUM_W'(1));
  assign fire   = in_win && last && !done_cur;

  always_comb begin
    win_bytes = in_sof ? '0 : win_q;
    if (in_win) begin
      for (int b = 0; b < FIELD_BYTES; b++) begin
        if (idx_b == IDX_W'(b))
          win_bytes[8*b +: 8] = in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      win_q      <= '0;
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
    end else if (beat) begin
      pos_q      <= (&pos_cur) ? pos_cur : pos_cur + POS_W'(1);
      win_q      <= win_bytes;
      in_frame_q <= !in_eof;
      done_q     <= done_cur || fire;
    end
  end
endmodule

// File: rtl/ffb_slot_cmp.sv
module ffb_slot_cmp
  import ffb_pkg::*;
#(
  parameter int FIELD_BYTES = 6
) (
  input  logic [8*FIELD_BYTES-1:0] win,
  input  logic [8*FIELD_BYTES-1:0] val,
  input  logic [8*FIELD_BYTES-1:0] mask,
  input  logic [8*FIELD_BYTES-1:0] care,
  input  logic [1:0]               kind,
  output logic                     hit
);
  localparam int FIELD_W = 8 * FIELD_BYTES;

  logic [FIELD_W-1:0] keep, a_be, v_be;

  assign keep = ~mask & care;

  always_comb begin
    for (int b = 0; b < FIELD_BYTES; b++) begin
      a_be[8*(FIELD_BYTES-1-b) +: 8] = win[8*b +: 8] & keep[8*b +: 8];
      v_be[8*(FIELD_BYTES-1-b) +: 8] = val[8*b +: 8] & keep[8*b +: 8];
    end
  end

  always_comb begin
    unique case (kind)
      KIND_EQ: hit = (a_be == v_be);
      KIND_GT: hit = (a_be > v_be);
      KIND_LT: hit = (a_be < v_be);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ffield_filter_bank.sv
module ffield_filter_bank
  import ffb_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int FIELD_BYTES = 6,
  parameter int ADDR_W      = 6,
  parameter int START_W     = 15,
  parameter int LEN_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [7:0]           in_data,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic                 match_valid,
  output logic [NUM_SLOTS-1:0] match_vec
);
  localparam int FIELD_W = 8 * FIELD_BYTES;

  logic [NUM_SLOTS-1:0][FIELD_W-1:0] cfg_val, cfg_mask;
  logic [NUM_SLOTS-1:0][1:0]         cfg_kind;
  logic [START_W-1:0]                cfg_start;
  logic [LEN_W-1:0]                  cfg_len, eff_len;
  logic [FIELD_W-1:0]                win_bytes, care;
  logic                              win_fire, sof_beat;
  logic [NUM_SLOTS-1:0]              hits;

  assign in_ready = 1'b1;
  assign sof_beat = in_valid && in_sof;

  ffb_cfg_regs #(
    .NUM_SLOTS(NUM_SLOTS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W),
    .START_W(START_W), .LEN_W(LEN_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .load(sof_beat), .cur_val(cfg_val),
    .cur_mask(cfg_mask), .cur_kind(cfg_kind), .cur_start(cfg_start),
    .cur_len(cfg_len)
  );

  ffb_window_capture #(
    .FIELD_BYTES(FIELD_BYTES), .START_W(START_W), .LEN_W(LEN_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .win_start(cfg_start),
    .win_len(cfg_len), .win_bytes(win_bytes), .eff_len(eff_len),
    .fire(win_fire)
  );

  always_comb begin
    for (int b = 0; b < FIELD_BYTES; b++)
      care[8*b +: 8] = (LEN_W'(b) < eff_len) ? 8'hFF : 8'h00;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    ffb_slot_cmp #(.FIELD_BYTES(FIELD_BYTES)) u_slot (
      .win(win_bytes), .val(cfg_val[s]), .mask(cfg_mask[s]),
      .care(care), .kind(cfg_kind[s]), .hit(hits[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_vec   <= '0;
      match_valid <= 1'b0;
    end else begin
      match_valid <= win_fire;
      if (win_fire)
        match_vec <= hits;
      else if (sof_beat)
        match_vec <= '0;
    end
  end
endmodule

// File: rtl/ffb_checker.sv
module ffb_checker #(
  parameter int NUM_SLOTS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_sof,
  input logic                      in_ready,
  input logic                      match_valid,
  input logic [NUM_SLOTS-1:0]      match_vec,
  input logic [NUM_SLOTS-1:0][1:0] cur_kind,
  input logic                      win_fire
);
  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  p_valid_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(in_valid));

  p_sof_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !win_fire) |=> (match_vec == '0));

  p_vec_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_valid && !$past(in_valid && in_sof)) |-> $stable(match_vec));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_off
    p_off_never_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_fire && cur_kind[s] == 2'd0) |=> !match_vec[s]);
  end
endmodule

bind ffield_filter_bank ffb_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_ready(in_ready), .match_valid(match_valid), .match_vec(match_vec),
  .cur_kind(cfg_kind), .win_fire(win_fire)
);

// File: tb/ffield_filter_bank_tb_top.sv
`timescale 1ns/1ps
module ffield_filter_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_ready, match_valid;
  logic [7:0]  match_vec;

  int vectors = 0, miscompares = 0;
  logic [7:0] fbuf [0:15];
  int valid_cnt, valid_beats, beats;
  logic [7:0] res_vec, sof_vec;
  bit sof_taken;

  always #2 clk = ~clk;

  ffield_filter_bank dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .match_valid(match_valid),
    .match_vec(match_vec)
  );

  localparam logic [55:0] VECS [8] = '{
    {48'hFFFFFFFFFFFF, 8'hA5}, {48'h0180C200000E, 8'h2E},
    {48'h000000000010, 8'h28}, {48'h000000000011, 8'h2C},
    {48'hAABBCCDDEEFF, 8'hE4}, {48'h80123456789A, 8'h24},
    {48'h020000000000, 8'h24}, {48'h810000000000, 8'hA4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_w(input logic [47:0] be);
    return {be[23:16], be[31:24], be[39:32], be[47:40]};
  endfunction
  function automatic logic [31:0] hi_w(input logic [47:0] be);
    return {16'h0, be[7:0], be[15:8]};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog_slot(input int s, input logic [47:0] v, input logic [47:0] m);
    wr(4*s, lo_w(v)); wr(4*s+1, hi_w(v));
    wr(4*s+2, lo_w(m)); wr(4*s+3, hi_w(m));
  endtask

  task automatic sample();
    if (match_valid) begin
      valid_cnt++; valid_beats = beats; res_vec = match_vec;
    end
    if (beats == 1 && !sof_taken) begin
      sof_vec = match_vec; sof_taken = 1'b1;
    end
  endtask

  task automatic send_frame(input int n, input bit gap);
    valid_cnt = 0; valid_beats = 0; beats = 0; res_vec = 0; sof_vec = 0; sof_taken = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample();
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n-1); in_data = fbuf[i];
      beats++;
      if (gap) begin
        @(negedge clk); sample();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    @(negedge clk); sample();
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(negedge clk); sample();
  endtask

  task automatic load_da(input logic [47:0] da);
    for (int b = 0; b < 6; b++) fbuf[b] = da[47-8*b -: 8];
    for (int b = 6; b < 16; b++) fbuf[b] = 8'(8'h50 + b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] kinds;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 match_vec", 32'(match_vec), 0);
    chk("R1 match_valid", 32'(match_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 1);

    // R2 register map programming
    prog_slot(0, 48'hFFFFFFFFFFFF, 48'h0);
    prog_slot(1, 48'h0180C2000000, 48'h0000000000FF);
    prog_slot(2, 48'h000000000010, 48'h0);
    prog_slot(3, 48'h020000000000, 48'h0);
    prog_slot(4, 48'h0, 48'h0);
    prog_slot(5, 48'h0, 48'hFFFFFFFFFFFF);
    prog_slot(6, 48'hAABBCCDDEEFF, 48'h0);
    prog_slot(7, 48'h800000000000, 48'h00FFFFFFFFFF);
    kinds = 32'h0;
    kinds |= 32'd1 << 0;  kinds |= 32'd1 << 2;  kinds |= 32'd2 << 4;
    kinds |= 32'd3 << 6;  kinds |= 32'd1 << 10; kinds |= 32'd1 << 12;
    kinds |= 32'd2 << 14;
    wr(32, kinds);
    wr(33, 32'h0006_0000);

    for (int v = 0; v < 8; v++) begin
      load_da(VECS[v][55:8]);
      send_frame(10, 1'b0);
      chk("R6 valid count", valid_cnt, 1);
      chk("R6 valid timing", valid_beats, 6);
      chk("R2/R3/R4 vec", 32'(res_vec), 32'(VECS[v][7:0]));
      chk("R5 off slot bit", 32'(res_vec[4]), 0);
      if (v > 0) chk("R6 cleared at sof", 32'(sof_vec), 0);
    end

    // R7 frame too short
    load_da(48'hFFFFFFFFFFFF);
    send_frame(4, 1'b0);
    chk("R7 no valid", valid_cnt, 0);
    chk("R7 vec zero", 32'(match_vec), 0);

    // R10 idle gaps, then stray beats after eof
    load_da(48'hAABBCCDDEEFF);
    send_frame(10, 1'b1);
    chk("R10 gap valid count", valid_cnt, 1);
    chk("R10 gap vec", 32'(res_vec), 32'hE4);
    valid_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (match_valid) valid_cnt++;
      in_valid = 1'b1; in_data = 8'hFF;
    end
    @(negedge clk); if (match_valid) valid_cnt++;
    in_valid = 1'b0;
    @(negedge clk); if (match_valid) valid_cnt++;
    chk("R10 stray beats no valid", valid_cnt, 0);
    chk("R10 stray beats vec held", 32'(match_vec), 32'hE4);

    // R11 source-address window
    wr(33, 32'h0006_0006);
    load_da(48'hAABBCCDDEEFF);
    for (int b = 6; b < 12; b++) fbuf[b] = 8'hFF;
    send_frame(14, 1'b0);
    chk("R11 sa timing", valid_beats, 12);
    chk("R11 sa vec", 32'(res_vec), 32'hA5);

    // R8 length handling
    wr(33, 32'h0008_0000);
    load_da(48'hFFFFFFFFFFFF);
    send_frame(10, 1'b0);
    chk("R8 clamp timing", valid_beats, 6);
    chk("R8 clamp vec", 32'(res_vec), 32'hA5);
    wr(33, 32'h0003_0000);
    load_da(48'hFFFFFF000000);
    send_frame(10, 1'b0);
    chk("R8 short timing", valid_beats, 3);
    chk("R8 short vec", 32'(res_vec), 32'hA5);
    wr(33, 32'h0000_0000);
    send_frame(10, 1'b0);
    chk("R8 zero length no valid", valid_cnt, 0);

    // R9 write in the middle of a frame
    wr(33, 32'h0006_0000);
    load_da(48'hAABBCCDDEEFF);
    fork
      send_frame(10, 1'b0);
      begin
        repeat (3) @(negedge clk);
        wr(24, 32'hFFFFFFFF);
        wr(25, 32'h0000FFFF);
      end
    join
    chk("R9 frame keeps old settings", 32'(res_vec), 32'hE4);
    load_da(48'hFFFFFFFFFFFF);
    send_frame(10, 1'b0);
    chk("R9 next frame uses new settings", 32'(res_vec), 32'hE5);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule